// File: doc/BRIEF.md
# Floating-Point Status Condition and Exception Updater

This block holds the 32-bit status word of a floating-point unit and keeps it current as instructions complete. Two update ports act on it. The result port carries the sign and class of a value the datapath has just produced. It rewrites the condition nibble to match that value. The fold port marks the end of an instruction. It merges the per-instruction exception byte into a set of sticky accrued flags. It then tests the exception byte against the enable byte of a control word supplied by the surrounding unit, and raises a trap request when an enabled exception is present.

Software or a context restore can also load the whole word through a direct write port. A direct write overrides both update ports in the same cycle. Producing results and servicing traps belong to neighbouring blocks.

Status word layout:
- Condition nibble: bit 27 negative, bit 26 zero, bit 25 infinity, bit 24 NaN.
- Exception byte: bit 15 unordered-branch, bit 14 signalling NaN, bit 13 operand error, bit 12 overflow, bit 11 underflow, bit 10 divide-by-zero, bit 9 inexact result, bit 8 inexact operand.
- Accrued bits: bit 7 invalid, bit 6 overflow, bit 5 underflow, bit 4 divide-by-zero, bit 3 inexact.
- Other bits: kept as written.

The enable byte of the control word uses the same positions as the exception byte, bits 15:8.

Top module: `fp_status_unit`

## Requirements
- R1: After reset the status word is 0 and trap_req is 0.
- R2: A result update clears bits 27:24 and then sets bit 27 (negative) equal to res_sign, for every result class.
- R3: The result class is encoded in res_class as follows: 0 number, 1 zero, 2 infinity, 3 quiet NaN, 4 signalling NaN, and 5 to 7 treated as number. Zero sets bit 26 only, infinity sets bit 25 only, either NaN sets bit 24 only, and a number sets none of bits 26:24.
- R4: A signalling-NaN result also sets exception bit 14. A result update leaves every bit outside 27:24 unchanged, apart from that bit 14.
- R5: A fold sets accrued bit 7 when any of exception bits 15, 14 or 13 is set.
- R6: A fold sets accrued bit 6 when exception bit 12 is set, and sets accrued bit 4 when exception bit 10 is set.
- R7: A fold sets accrued bit 5 only when exception bits 11 and 9 are both set.
- R8: A fold sets accrued bit 3 when any of exception bits 9, 8 or 12 is set.
- R9: A fold only ORs into bits 7:3. It never clears an accrued bit and leaves the exception byte unchanged.
- R10: trap_req is 1 in the cycle after a fold exactly when (status bits 15:8 AND ctrl_word bits 15:8) is nonzero. It is 0 after any cycle without a fold.
- R11: When wr_en is high, the status word takes wr_data on the next edge, whatever res_en and fold_en request, and trap_req is 0 in the following cycle.
- R12: When res_en and fold_en are high in the same cycle, the fold acts on the word as already changed by the result update, so a signalling-NaN result is folded and can trap in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Direct load of the whole status word |
| wr_data | input | 32 | Value loaded by wr_en |
| ctrl_word | input | 32 | Control word; bits 15:8 enable traps per exception |
| res_en | input | 1 | Result update strobe |
| res_sign | input | 1 | Sign of the result |
| res_class | input | 3 | Class of the result (encoding in R3) |
| fold_en | input | 1 | End-of-instruction exception fold strobe |
| status_word | output | 32 | Current status word |
| trap_req | output | 1 | Trap request, registered |

## Verification
A fault in the status register appears on status_word one cycle after the update that produced it, since the word is driven straight from the register. A fault in the accrued-bit mapping appears immediately after the fold that should have set or kept a bit. It also persists into every later read, because nothing but a write can clear those bits. A fault in the trap path appears as a wrong trap_req one cycle after a fold, or as a trap_req that stays high past the following idle cycle.

// File: rtl/fp_status_unit.sv
module fp_status_unit #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic              res_en,
  input  logic              res_sign,
  input  logic [2:0]        res_class,
  input  logic              fold_en,
  output logic [WORD_W-1:0] status_word,
  output logic              trap_req
);
  localparam int C_NEG  = 27;
  localparam int C_ZERO = 26;
  localparam int C_INF  = 25;
  localparam int C_NAN  = 24;

  localparam int X_BSUN = 15;
  localparam int X_SNAN = 14;
  localparam int X_OPER = 13;
  localparam int X_OVFL = 12;
  localparam int X_UNFL = 11;
  localparam int X_DZ   = 10;
  localparam int X_INXR = 9;
  localparam int X_INXO = 8;
  localparam int X_LO   = 8;
  localparam int X_HI   = 15;

  localparam int A_IOP  = 7;
  localparam int A_OVFL = 6;
  localparam int A_UNFL = 5;
  localparam int A_DZ   = 4;
  localparam int A_INEX = 3;

  localparam logic [2:0] CL_ZERO = 3'd1;
  localparam logic [2:0] CL_INF  = 3'd2;
  localparam logic [2:0] CL_QNAN = 3'd3;
  localparam logic [2:0] CL_SNAN = 3'd4;

  logic [WORD_W-1:0] sw_q, after_res, after_fold, sw_d;
  logic              trap_d;

  always_comb begin
    after_res = sw_q;
    if (res_en) begin
      after_res[C_NEG:C_NAN] = '0;
      after_res[C_NEG]       = res_sign;
      unique case (res_class)
        CL_ZERO: after_res[C_ZERO] = 1'b1;
        CL_INF:  after_res[C_INF]  = 1'b1;
        CL_QNAN: after_res[C_NAN]  = 1'b1;
        CL_SNAN: begin
          after_res[C_NAN]  = 1'b1;
          after_res[X_SNAN] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    after_fold = after_res;
    if (fold_en) begin
      after_fold[A_IOP]  = after_res[A_IOP]  | after_res[X_BSUN] | after_res[X_SNAN] | after_res[X_OPER];
      after_fold[A_OVFL] = after_res[A_OVFL] | after_res[X_OVFL];
      after_fold[A_UNFL] = after_res[A_UNFL] | (after_res[X_UNFL] & after_res[X_INXR]);
      after_fold[A_DZ]   = after_res[A_DZ]   | after_res[X_DZ];
      after_fold[A_INEX] = after_res[A_INEX] | after_res[X_INXR] | after_res[X_INXO] | after_res[X_OVFL];
    end
  end

  assign sw_d   = wr_en ? wr_data : after_fold;
  assign trap_d = !wr_en && fold_en && |(after_fold[X_HI:X_LO] & ctrl_word[X_HI:X_LO]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q     <= '0;
      trap_req <= 1'b0;
    end else begin
      sw_q     <= sw_d;
      trap_req <= trap_d;
    end
  end

  assign status_word = sw_q;
endmodule

// File: rtl/fp_status_unit_chk.sv
module fp_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        res_en,
  input logic        res_sign,
  input logic        fold_en,
  input logic [31:0] status_word,
  input logic        trap_req
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk) $past(!rst_n) |-> (status_word == 32'h0 && !trap_req));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en)) |-> (status_word == $past(wr_data) && !trap_req));

  p_trap_needs_fold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && trap_req) |-> $past(fold_en && !wr_en));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(wr_en)) |-> ((status_word[7:3] & $past(status_word[7:3])) == $past(status_word[7:3])));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(res_en && !wr_en)) |-> (status_word[27] == $past(res_sign)));

  p_class_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(res_en && !wr_en)) |-> $onehot0(status_word[26:24]));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!wr_en && !res_en && !fold_en)) |-> $stable(status_word));
endmodule

bind fp_status_unit fp_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .res_en(res_en), .res_sign(res_sign), .fold_en(fold_en),
  .status_word(status_word), .trap_req(trap_req)
);

// File: tb/fp_status_unit_tb.sv
module fp_status_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_word = '0;
  logic        res_en = 1'b0;
  logic        res_sign = 1'b0;
  logic [2:0]  res_class = '0;
  logic        fold_en = 1'b0;
  logic [31:0] status_word;
  logic        trap_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_word(ctrl_word), .res_en(res_en), .res_sign(res_sign),
    .res_class(res_class), .fold_en(fold_en),
    .status_word(status_word), .trap_req(trap_req)
  );

  function automatic logic [31:0] res_model(logic [31:0] s, logic sg, logic [2:0] c);
    logic [31:0] r = s;
    r[27:24] = '0;
    r[27] = sg;
    if (c == 3'd1) r[26] = 1'b1;
    if (c == 3'd2) r[25] = 1'b1;
    if (c == 3'd3 || c == 3'd4) r[24] = 1'b1;
    if (c == 3'd4) r[14] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] fold_model(logic [31:0] s);
    logic [31:0] r = s;
    if (s[15] || s[14] || s[13]) r[7] = 1'b1;
    if (s[12]) r[6] = 1'b1;
    if (s[11] && s[9]) r[5] = 1'b1;
    if (s[10]) r[4] = 1'b1;
    if (s[9] || s[8] || s[12]) r[3] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_op(bit r, logic sg, logic [2:0] c, bit f);
    @(negedge clk);
    res_en = r; res_sign = sg; res_class = c; fold_en = f;
    @(negedge clk);
    res_en = 1'b0; fold_en = 1'b0;
  endtask

  initial begin
    logic [31:0] exp_w;
    repeat (3) @(negedge clk);
    check(status_word == 32'h0, "R1", status_word, 32'h0);
    check(trap_req == 1'b0, "R1", {31'h0, trap_req}, 32'h0);
    rst_n = 1'b1;

    // result port sweep over presets, signs and classes
    for (int p = 0; p < 3; p++) begin
      logic [31:0] pre;
      pre = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF : 32'h0F00_3C18;
      for (int sg = 0; sg < 2; sg++) begin
        for (int c = 0; c < 8; c++) begin
          do_write(pre);
          do_op(1'b1, sg[0], c[2:0], 1'b0);
          exp_w = res_model(pre, sg[0], c[2:0]);
          check(status_word[27] == exp_w[27], "R2", status_word, exp_w);
          check(status_word[26:24] == exp_w[26:24], "R3", status_word, exp_w);
          check({status_word[31:28], status_word[23:0]} == {exp_w[31:28], exp_w[23:0]}, "R4", status_word, exp_w);
        end
      end
    end

    // fold sweep: every exception byte against several enable masks
    for (int k = 0; k < 9; k++) begin
      ctrl_word = (k == 8) ? 32'h0 : (32'h100 << k);
      for (int e = 0; e < 256; e++) begin
        logic [31:0] pre;
        logic t_exp;
        pre = {16'h0, e[7:0], 8'h00};
        do_write(pre);
        do_op(1'b0, 1'b0, 3'd0, 1'b1);
        exp_w = fold_model(pre);
        t_exp = |(pre[15:8] & ctrl_word[15:8]);
        check(status_word[7] == exp_w[7], "R5", status_word, exp_w);
        check(status_word[6] == exp_w[6] && status_word[4] == exp_w[4], "R6", status_word, exp_w);
        check(status_word[5] == exp_w[5], "R7", status_word, exp_w);
        check(status_word[3] == exp_w[3], "R8", status_word, exp_w);
        check(status_word[15:8] == pre[15:8], "R9", status_word, pre);
        check(trap_req == t_exp, "R10", {31'h0, trap_req}, {31'h0, t_exp});
        if (t_exp) begin
          @(negedge clk);
          check(trap_req == 1'b0, "R10", {31'h0, trap_req}, 32'h0);
        end
      end
    end

    // sticky accrued bits survive a fold with no exceptions
    ctrl_word = 32'h0000_FF00;
    do_write(32'h0000_00F8);
    do_op(1'b0, 1'b0, 3'd0, 1'b1);
    check(status_word == 32'h0000_00F8, "R9", status_word, 32'h0000_00F8);
    check(trap_req == 1'b0, "R10", {31'h0, trap_req}, 32'h0);

    // direct write beats both update ports and clears accrued
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_FF00; res_en = 1'b1; res_sign = 1'b1;
    res_class = 3'd4; fold_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; res_en = 1'b0; fold_en = 1'b0;
    check(status_word == 32'h0000_FF00, "R11", status_word, 32'h0000_FF00);
    check(trap_req == 1'b0, "R11", {31'h0, trap_req}, 32'h0);
    do_write(32'h0);
    check(status_word == 32'h0, "R11", status_word, 32'h0);

    // result and fold in the same cycle
    ctrl_word = 32'h0000_4000;
    do_op(1'b1, 1'b0, 3'd4, 1'b1);
    check(status_word == 32'h0100_4080, "R12", status_word, 32'h0100_4080);
    check(trap_req == 1'b1, "R12", {31'h0, trap_req}, 32'h1);
    ctrl_word = 32'h0000_0100;
    do_write(32'h0);
    do_op(1'b1, 1'b1, 3'd3, 1'b1);
    check(status_word == 32'h0900_0000, "R12", status_word, 32'h0900_0000);
    check(trap_req == 1'b0, "R12", {31'h0, trap_req}, 32'h0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule